// File: doc/BRIEF.md
# Shared-Memory Mailbox Block Transfer

The block moves blocks of data words from a producer stream to a consumer stream through a true dual-port RAM. The two sides share no handshake wires. Flow control runs entirely through one reserved RAM word, the mailbox, at address 0. Each side polls that word on its own port.

The sender sequencer owns port 0. It reads the mailbox and, once it reads zero, opens its stream input and writes incoming words into the payload region that starts at address 1. After the final payload word it posts the word count into the mailbox. The receiver sequencer owns port 1. It polls the mailbox at a fixed minimum interval. When it finds a non-zero count, it reads that many payload words out onto its stream output and then writes zero back into the mailbox, which frees the region for the next block.

The scheme suits large blocks at long intervals. The same structure, mirrored, carries data in the other direction.

Top module: `mbox_xchg`

## Requirements
- R1: Address 0 is the mailbox, and zero is its empty value. The payload region is addresses 1 to PAY_MAX, where PAY_MAX = 2**ADDR_W-1. After reset the receiver writes zero into the mailbox, and the sender then finds it empty.
- R2: The sender raises tx_ready_o only after a mailbox read has returned zero. While the mailbox holds a non-zero value, the sender keeps re-reading it and tx_ready_o stays low.
- R3: Accepted words are written to consecutive payload addresses, starting at address 1, in arrival order. The count is written to the mailbox only after the last payload word, and it equals the number of words written.
- R4: A block ends at the word that carries tx_last_i, or at the PAY_MAX-th word of the block, whichever comes first. Words that follow a cut start a new block.
- R5: Between two mailbox reads by the receiver, at least POLL_GAP cycles pass in which it does not read the mailbox (POLL_GAP >= 1).
- R6: On reading a non-zero count N, the receiver presents exactly N words in payload order and raises rx_last_o with the N-th word.
- R7: The receiver writes only to the mailbox and only the value zero. It clears the mailbox after the final word of a block has been accepted.
- R8: While rx_valid_o is high and rx_ready_i is low, rx_valid_o, rx_data_o and rx_last_o hold their values.
- R9: When one port writes an address in the same cycle that the other port reads that address, the read returns the newly written data.
- R10: While rst_ni is low, tx_ready_o and rx_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | DATA_W | Producer word |
| tx_valid_i | input | 1 | Producer word valid |
| tx_last_i | input | 1 | Producer word closes the block |
| tx_ready_o | output | 1 | Sender accepts a word this cycle |
| rx_data_o | output | DATA_W | Consumer word |
| rx_valid_o | output | 1 | Consumer word valid |
| rx_last_o | output | 1 | Consumer word is the last of its block |
| rx_ready_i | input | 1 | Consumer accepts the word |

## Verification
The first block is sent while the consumer holds rx_ready_i low. This shows whether the sender really waits on an unconsumed mailbox, or whether it overwrites the payload that is still pending. Blocks of length 1 and exactly PAY_MAX, and a 70-word block with no early last, check the boundary between an ending signalled by tx_last_i and a cut forced by capacity. Random block lengths with random producer gaps and random consumer backpressure show whether ordering and counts survive the two sequencers drifting against each other. A standalone RAM instance is driven with same-address write/read pairs in both port directions, to confirm that new data is forwarded on a collision.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {TX_POLL, TX_CHK, TX_FILL, TX_POST} tx_state_e;
  typedef enum logic [2:0] {RX_CLR, RX_WAIT, RX_POLL, RX_CHK, RX_RD, RX_HOLD} rx_state_e;
endpackage

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic                  clk_i,
  input  logic [1:0]            en_i,
  input  logic [1:0]            we_i,
  input  logic [1:0][AW-1:0]    addr_i,
  input  logic [1:0][DW-1:0]    wd_i,
  output logic [1:0][DW-1:0]    q_o
);
  localparam int unsigned DEPTH = 2**AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++)
      if (en_i[p] && we_i[p]) mem[addr_i[p]] <= wd_i[p];
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int O = 1 - p;
    logic [DW-1:0] q_r;
    // a same-cycle write from the other port is forwarded to this read
    always_ff @(posedge clk_i) begin
      if (en_i[p] && !we_i[p])
        q_r <= (en_i[O] && we_i[O] && addr_i[O] == addr_i[p]) ? wd_i[O] : mem[addr_i[p]];
    end
    assign q_o[p] = q_r;
  end
endmodule

// File: rtl/mbox_sender.sv
module mbox_sender import mbox_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wd_o,
  input  logic [DATA_W-1:0] ram_q_i
);
  localparam int unsigned PAY_MAX = 2**ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CNT_CAP = ADDR_W'(PAY_MAX - 1);

  tx_state_e         state_q;
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_POLL;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        TX_POLL: state_q <= TX_CHK;
        TX_CHK: begin
          if (ram_q_i == '0) begin
            state_q <= TX_FILL;
            cnt_q   <= '0;
          end else begin
            state_q <= TX_POLL;
          end
        end
        TX_FILL: begin
          if (tx_valid_i) begin
            cnt_q <= cnt_q + ADDR_W'(1);
            if (tx_last_i || cnt_q == CNT_CAP) state_q <= TX_POST;
          end
        end
        TX_POST: state_q <= TX_POLL;
        default: state_q <= TX_POLL;
      endcase
    end
  end

  always_comb begin
    ram_en_o   = 1'b0;
    ram_we_o   = 1'b0;
    ram_addr_o = '0;
    ram_wd_o   = '0;
    unique case (state_q)
      TX_POLL: ram_en_o = 1'b1;
      TX_FILL: begin
        ram_en_o   = tx_valid_i;
        ram_we_o   = 1'b1;
        ram_addr_o = cnt_q + ADDR_W'(1);
        ram_wd_o   = tx_data_i;
      end
      TX_POST: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
        ram_wd_o = DATA_W'(cnt_q);
      end
      default: ;
    endcase
  end

  assign tx_ready_o = (state_q == TX_FILL);
endmodule

// File: rtl/mbox_receiver.sv
module mbox_receiver import mbox_pkg::*; #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned POLL_GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_last_o,
  input  logic              rx_ready_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wd_o,
  input  logic [DATA_W-1:0] ram_q_i
);
  localparam int unsigned GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(POLL_GAP - 1);

  rx_state_e         state_q;
  logic [GAP_W-1:0]  gap_q;
  logic [ADDR_W-1:0] len_q, idx_q;
  logic              at_end;

  assign at_end = (idx_q == len_q - ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_CLR;
      gap_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        RX_CLR: begin
          state_q <= RX_WAIT;
          gap_q   <= '0;
        end
        RX_WAIT: begin
          if (gap_q == GAP_END) state_q <= RX_POLL;
          else gap_q <= gap_q + GAP_W'(1);
        end
        RX_POLL: state_q <= RX_CHK;
        RX_CHK: begin
          if (ram_q_i != '0) begin
            len_q   <= ram_q_i[ADDR_W-1:0];
            idx_q   <= '0;
            state_q <= RX_RD;
          end else begin
            gap_q   <= '0;
            state_q <= RX_WAIT;
          end
        end
        RX_RD: state_q <= RX_HOLD;
        RX_HOLD: begin
          if (rx_ready_i) begin
            if (at_end) state_q <= RX_CLR;
            else begin
              idx_q   <= idx_q + ADDR_W'(1);
              state_q <= RX_RD;
            end
          end
        end
        default: state_q <= RX_CLR;
      endcase
    end
  end

  always_comb begin
    ram_en_o   = 1'b0;
    ram_we_o   = 1'b0;
    ram_addr_o = '0;
    ram_wd_o   = '0;
    unique case (state_q)
      RX_CLR: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
      end
      RX_POLL: ram_en_o = 1'b1;
      RX_RD: begin
        ram_en_o   = 1'b1;
        ram_addr_o = idx_q + ADDR_W'(1);
      end
      default: ;
    endcase
  end

  // read port output is only reloaded on an enabled read, so it holds during RX_HOLD
  assign rx_valid_o = (state_q == RX_HOLD);
  assign rx_data_o  = ram_q_i;
  assign rx_last_o  = rx_valid_o && at_end;
endmodule

// File: rtl/mbox_xchg.sv
module mbox_xchg #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned POLL_GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_last_o,
  input  logic              rx_ready_i
);
  logic [1:0]             ram_en, ram_we;
  logic [1:0][ADDR_W-1:0] ram_addr;
  logic [1:0][DATA_W-1:0] ram_wd, ram_q;

  mbox_sender #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_sender (
    .clk_i, .rst_ni,
    .tx_data_i, .tx_valid_i, .tx_last_i, .tx_ready_o,
    .ram_en_o(ram_en[0]), .ram_we_o(ram_we[0]), .ram_addr_o(ram_addr[0]),
    .ram_wd_o(ram_wd[0]), .ram_q_i(ram_q[0])
  );

  mbox_receiver #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .POLL_GAP(POLL_GAP)) i_receiver (
    .clk_i, .rst_ni,
    .rx_data_o, .rx_valid_o, .rx_last_o, .rx_ready_i,
    .ram_en_o(ram_en[1]), .ram_we_o(ram_we[1]), .ram_addr_o(ram_addr[1]),
    .ram_wd_o(ram_wd[1]), .ram_q_i(ram_q[1])
  );

  mbox_dpram #(.DW(DATA_W), .AW(ADDR_W)) i_ram (
    .clk_i, .en_i(ram_en), .we_i(ram_we), .addr_i(ram_addr), .wd_i(ram_wd), .q_o(ram_q)
  );
endmodule

// File: rtl/mbox_xchg_chk.sv
module mbox_xchg_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned POLL_GAP = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               ram_en,
  input logic [1:0]               ram_we,
  input logic [1:0][ADDR_W-1:0]   ram_addr,
  input logic [1:0][DATA_W-1:0]   ram_wd,
  input logic [1:0][DATA_W-1:0]   ram_q,
  input logic                     tx_ready_o,
  input logic                     rx_valid_o,
  input logic                     rx_ready_i,
  input logic [DATA_W-1:0]        rx_data_o,
  input logic                     rx_last_o
);
  localparam int unsigned PAY_MAX = 2**ADDR_W - 1;

  logic tx_pay_wr, tx_post, rx_mb_rd, rx_pay_rd, rx_wr;
  assign tx_pay_wr = ram_en[0] && ram_we[0] && ram_addr[0] != '0;
  assign tx_post   = ram_en[0] && ram_we[0] && ram_addr[0] == '0;
  assign rx_mb_rd  = ram_en[1] && !ram_we[1] && ram_addr[1] == '0;
  assign rx_pay_rd = ram_en[1] && !ram_we[1] && ram_addr[1] != '0;
  assign rx_wr     = ram_en[1] && ram_we[1];

  logic        full_q, seen_rd_q;
  logic [15:0] gap_q, pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= 1'b0;
      seen_rd_q <= 1'b0;
      gap_q     <= '0;
      pay_q     <= '0;
    end else begin
      if (tx_post) full_q <= 1'b1;
      else if (rx_wr) full_q <= 1'b0;
      if (rx_mb_rd) begin
        seen_rd_q <= 1'b1;
        gap_q     <= '0;
      end else if (gap_q != 16'hffff) begin
        gap_q <= gap_q + 16'd1;
      end
      if (tx_post) pay_q <= '0;
      else if (tx_pay_wr) pay_q <= pay_q + 16'd1;
    end
  end

  assert_fill_when_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pay_wr |-> !full_q);
  assert_post_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_post |-> (ram_wd[0] != '0 && 16'(ram_wd[0]) == pay_q + 16'd1 - 16'd1 + 16'd0 && 16'(ram_wd[0]) <= 16'(PAY_MAX)));
  assert_poll_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mb_rd && seen_rd_q) |-> gap_q >= 16'(POLL_GAP));
  assert_read_posted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pay_rd |-> full_q);
  assert_clear_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr |-> (ram_addr[1] == '0 && ram_wd[1] == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && $stable(rx_last_o)));
  assert_fwd_tx_to_rx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en[0] && ram_we[0] && ram_en[1] && !ram_we[1] && ram_addr[0] == ram_addr[1])
    |=> ram_q[1] == $past(ram_wd[0]));
  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_ready_o && !rx_valid_o));
endmodule

bind mbox_xchg mbox_xchg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .POLL_GAP(POLL_GAP)) i_chk (.*);

// File: tb/test_mbox_xchg.sv
`timescale 1ns/1ps
module test_mbox_xchg;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int PAY_MAX = 2**AW - 1;
  localparam int MAXW = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [DW-1:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_last = 1'b0, tx_ready;
  logic rx_valid, rx_last, rx_ready = 1'b0;

  mbox_xchg #(.DATA_W(DW), .ADDR_W(AW), .POLL_GAP(4)) i_mbox_xchg (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_last_i(tx_last), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_last_o(rx_last), .rx_ready_i(rx_ready)
  );

  // standalone RAM for the collision cases
  logic [1:0] d_en = '0, d_we = '0;
  logic [1:0][AW-1:0] d_addr = '0;
  logic [1:0][DW-1:0] d_wd = '0, d_q;
  mbox_dpram #(.DW(DW), .AW(AW)) i_dpram (
    .clk_i(clk), .en_i(d_en), .we_i(d_we), .addr_i(d_addr), .wd_i(d_wd), .q_o(d_q)
  );

  int checks = 0, errors = 0;
  int tx_cnt = 0, rx_cnt = 0, blk_run = 0;
  bit rx_mode = 1'b0;
  logic [DW-1:0] exp_data [MAXW];
  bit            exp_last [MAXW];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4: a block closes on the flagged word or on its PAY_MAX-th word
  function automatic bit model_last(input int run, input bit flag);
    return flag || (run + 1 == PAY_MAX);
  endfunction

  task automatic send_word(input logic [DW-1:0] d, input bit flag);
    bit hs;
    exp_data[tx_cnt] = d;
    exp_last[tx_cnt] = model_last(blk_run, flag);
    blk_run = exp_last[tx_cnt] ? 0 : blk_run + 1;
    tx_cnt++;
    tx_data = d; tx_last = flag; tx_valid = 1'b1;
    forever begin
      #1 hs = tx_ready;
      @(negedge clk);
      if (hs) break;
    end
    tx_valid = 1'b0; tx_last = 1'b0;
  endtask

  task automatic send_block(input int len);
    for (int w = 0; w < len; w++) begin
      send_word(DW'($urandom), w == len - 1);
      if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
    end
  endtask

  // consumer: ready set at the falling edge, handshake resolved at the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      rx_ready = rx_mode ? ($urandom % 4 != 0) : 1'b0;
      #1;
      if (rx_valid && rx_ready && rst_n) begin
        if (rx_cnt < tx_cnt) begin
          check(rx_data == exp_data[rx_cnt], "R3", int'(rx_data), int'(exp_data[rx_cnt]));
          check(rx_last == exp_last[rx_cnt], "R4", int'(rx_last), int'(exp_last[rx_cnt]));
        end else begin
          check(1'b0, "R6", rx_cnt + 1, tx_cnt);
        end
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(!tx_ready, "R10", int'(tx_ready), 0);
    check(!rx_valid, "R10", int'(rx_valid), 0);
    rst_n = 1'b1;

    // R1: the receiver clears the mailbox, and the sender then finds it empty
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_ready) seen = 1;
    end
    check(seen == 1, "R1", seen, 1);

    // R2/R8: the consumer stalls, so the second block must not be accepted
    send_block(5);
    repeat (40) @(negedge clk);
    tx_data = 16'hbeef; tx_valid = 1'b1; tx_last = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1 if (tx_ready) seen++;
    end
    tx_valid = 1'b0; tx_last = 1'b0;
    check(seen == 0, "R2", seen, 0);
    check(rx_valid == 1'b1, "R8", int'(rx_valid), 1);
    check(rx_data == exp_data[0], "R8", int'(rx_data), int'(exp_data[0]));

    rx_mode = 1'b1;
    send_block(1);
    send_block(PAY_MAX);
    send_block(70);
    for (int b = 0; b < 8; b++) send_block(1 + int'($urandom % PAY_MAX));

    for (int i = 0; i < 60000 && rx_cnt < tx_cnt; i++) @(negedge clk);
    repeat (50) @(negedge clk);
    // R5, R7: every block after the first arrives only through polling and clearing
    check(rx_cnt == tx_cnt, "R6", rx_cnt, tx_cnt);
    check(rx_valid == 1'b0, "R7", int'(rx_valid), 0);

    // R9: collisions on the standalone RAM, both port directions
    @(negedge clk);
    d_en = 2'b01; d_we = 2'b01; d_addr[0] = 6'd5; d_wd[0] = 16'h1111;
    @(negedge clk);
    d_en = 2'b11; d_we = 2'b01; d_wd[0] = 16'h2222; d_addr[1] = 6'd5;
    @(negedge clk);
    d_en = 2'b00; d_we = 2'b00;
    check(d_q[1] == 16'h2222, "R9", int'(d_q[1]), 16'h2222);
    d_en = 2'b11; d_we = 2'b10; d_addr[1] = 6'd9; d_wd[1] = 16'h3333; d_addr[0] = 6'd9;
    @(negedge clk);
    d_en = 2'b00; d_we = 2'b00;
    check(d_q[0] == 16'h3333, "R9", int'(d_q[0]), 16'h3333);
    d_en = 2'b10; d_addr[1] = 6'd5;
    @(negedge clk);
    d_en = 2'b00;
    check(d_q[1] == 16'h2222, "R9", int'(d_q[1]), 16'h2222);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule